// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a flash device. It decides whether a program or erase operation inside the flash has finished. Software gives it a start pulse. The poller then reads the device's status byte through a simple request/acknowledge read port. It compares one selected toggle bit between two consecutive reads. It also looks at the timeout flag, which is status bit 5.

If the toggle bit holds steady across a pair of reads, the operation is finished, and the poller pulses `done_ok`. While the bit keeps changing and the timeout flag is clear, the poller starts a fresh pair of reads. If the bit is changing and the timeout flag is set, the poller takes one more pair of reads. This guards against an operation that finished at the same moment the flag rose.

A change on that recheck pair counts as a real failure. The poller then writes the reset command byte F0h and pulses `done_fail`. A pair-count limit forces the same failure path if the bit never settles. Software can leave polling early with `abort`; the next start always begins with a new first read.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it, `busy`, `rd_req`, `wr_req`, `done_ok` and `done_fail` are all low.
- R2: A `start` seen while idle raises `busy` and `rd_req` on the next cycle, and a `start` seen while busy has no effect. A read completes in every cycle where `rd_req` and `rd_ack` are both high, and `rd_data` is sampled in that cycle. `rd_req` stays high until `rd_ack` arrives.
- R3: Each pair is two consecutive completed reads. When the selected toggle bit is equal in both reads, `done_ok` pulses on the cycle after the second read, and no write is issued.
- R4: When the toggle bit differs and bit 5 of the second read is 0, a new pair starts on the next cycle. The toggle bit of that pair's own first read is the one stored for comparison.
- R5: When the toggle bit differs and bit 5 of the second read is 1, exactly one recheck pair is read. If the toggle bit is equal across the recheck pair, `done_ok` pulses and no write is issued.
- R6: When the toggle bit still differs on the recheck pair, `wr_req` rises with `wr_data` = F0h and stays high until `wr_ack`. `done_fail` pulses on the cycle after the acknowledge.
- R7: `bit_sel` is sampled on the accepted `start`. A value of 0 selects status bit 6 as the toggle bit, and 1 selects status bit 2.
- R8: `abort` during any read step returns the block to idle on the next cycle, with neither done pulse, and any read acknowledged in that cycle is discarded. The next `start` begins again with a new first read. `abort` has no effect during the reset-command write.
- R9: After MAX_PAIRS normal pairs in a row that all show toggling with bit 5 clear, the block takes the failure path of R6.
- R10: `done_ok` and `done_fail` are single-cycle pulses and never high together. `busy` stays high from the cycle after an accepted `start` up to the cycle in which either pulse appears, or until an abort; `busy` is low in the pulse cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a completion check |
| abort | input | 1 | Leave polling early |
| bit_sel | input | 1 | Toggle bit choice: 0 = bit 6, 1 = bit 2 |
| rd_req | output | 1 | Status read request |
| rd_ack | input | 1 | Read completes this cycle |
| rd_data | input | 8 | Status byte, valid with `rd_ack` |
| wr_req | output | 1 | Reset-command write request |
| wr_data | output | 8 | Command byte (F0h) |
| wr_ack | input | 1 | Write accepted this cycle |
| busy | output | 1 | Polling in progress |
| done_ok | output | 1 | One-cycle success pulse |
| done_fail | output | 1 | One-cycle failure pulse |

## Verification
A wrong stored first byte, or a stale toggle-bit selection, shows up as a pair that ends in the wrong verdict. That error appears on `done_ok`, `rd_req` or `wr_req` one cycle after the pair's second read. A wrong pair count or a recheck that is skipped changes how many reads the block consumes before it finishes, so the read total and the cycle of the pulse both move. State that survives an abort shows up on the first pair after the restart. The reference model catches each of these within one clock, because it compares every output on every cycle.

// File: rtl/toggle_poll_pkg.sv
package toggle_poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_FIRST,
    ST_RD_SECOND,
    ST_RC_FIRST,
    ST_RC_SECOND,
    ST_CMD_WR
  } poll_state_t;

  // Pick the toggle bit from a status byte: sel=0 -> pos_a, sel=1 -> pos_b
  function automatic logic pick_bit(input logic [7:0] stat, input logic sel,
                                    input int pos_a, input int pos_b);
    return sel ? stat[pos_b] : stat[pos_a];
  endfunction

  // Toggle seen between two reads of the same status byte
  function automatic logic bit_moved(input logic [7:0] older, input logic [7:0] newer,
                                     input logic sel, input int pos_a, input int pos_b);
    return pick_bit(older, sel, pos_a, pos_b) ^ pick_bit(newer, sel, pos_a, pos_b);
  endfunction

endpackage

// File: rtl/tp_compare.sv
module tp_compare #(
  parameter int DATA_W  = 8,
  parameter int POS_A   = 6,
  parameter int POS_B   = 2,
  parameter int FLAG_POS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_sel,
  input  logic              sel_in,
  input  logic              cap_first,
  input  logic [DATA_W-1:0] rd_data,
  output logic              toggled,
  output logic              flag_set
);
  import toggle_poll_pkg::*;

  logic [DATA_W-1:0] first_q;
  logic              sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q <= '0;
      sel_q   <= 1'b0;
    end else begin
      if (load_sel)  sel_q   <= sel_in;
      if (cap_first) first_q <= rd_data;
    end
  end

  assign toggled  = bit_moved(first_q, rd_data, sel_q, POS_A, POS_B);
  assign flag_set = rd_data[FLAG_POS];
endmodule

// File: rtl/tp_pair_cnt.sv
module tp_pair_cnt #(
  parameter int MAX_PAIRS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CNT_W = $clog2(MAX_PAIRS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_PAIRS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (inc)  cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit = (cnt_q == LAST);
endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
  parameter int          DATA_W    = 8,
  parameter int          POS_A     = 6,
  parameter int          POS_B     = 2,
  parameter int          FLAG_POS  = 5,
  parameter int          MAX_PAIRS = 4096,
  parameter logic [7:0]  RESET_CMD = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              bit_sel,
  output logic              rd_req,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_req,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic              busy,
  output logic              done_ok,
  output logic              done_fail
);
  import toggle_poll_pkg::*;

  poll_state_t state_q, state_d;
  logic ok_q, fail_q;

  // named internal events
  logic start_acc, rd_go, in_read, in_recheck, abort_hit;
  logic first_cap, pair_end, toggled, flag_set, at_limit, pair_inc;

  assign in_read    = (state_q == ST_RD_FIRST) || (state_q == ST_RD_SECOND) ||
                      (state_q == ST_RC_FIRST) || (state_q == ST_RC_SECOND);
  assign in_recheck = (state_q == ST_RC_FIRST) || (state_q == ST_RC_SECOND);
  assign start_acc  = start && (state_q == ST_IDLE);
  assign abort_hit  = abort && in_read;
  assign rd_go      = rd_req && rd_ack && !abort_hit;
  assign first_cap  = rd_go && ((state_q == ST_RD_FIRST) || (state_q == ST_RC_FIRST));
  assign pair_end   = rd_go && ((state_q == ST_RD_SECOND) || (state_q == ST_RC_SECOND));
  assign pair_inc   = pair_end && !in_recheck && toggled && !flag_set && !at_limit;

  tp_compare #(
    .DATA_W(DATA_W), .POS_A(POS_A), .POS_B(POS_B), .FLAG_POS(FLAG_POS)
  ) u_cmp (
    .clk(clk), .rst_n(rst_n), .load_sel(start_acc), .sel_in(bit_sel),
    .cap_first(first_cap), .rd_data(rd_data), .toggled(toggled), .flag_set(flag_set)
  );

  tp_pair_cnt #(.MAX_PAIRS(MAX_PAIRS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(start_acc), .inc(pair_inc), .at_limit(at_limit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (start_acc) state_d = ST_RD_FIRST;
      ST_RD_FIRST:  if (abort_hit) state_d = ST_IDLE;
                    else if (first_cap) state_d = ST_RD_SECOND;
      ST_RD_SECOND: if (abort_hit) state_d = ST_IDLE;
                    else if (pair_end) begin
                      if (!toggled)      state_d = ST_IDLE;
                      else if (flag_set) state_d = ST_RC_FIRST;
                      else if (at_limit) state_d = ST_CMD_WR;
                      else               state_d = ST_RD_FIRST;
                    end
      ST_RC_FIRST:  if (abort_hit) state_d = ST_IDLE;
                    else if (first_cap) state_d = ST_RC_SECOND;
      ST_RC_SECOND: if (abort_hit) state_d = ST_IDLE;
                    else if (pair_end) state_d = toggled ? ST_CMD_WR : ST_IDLE;
      ST_CMD_WR:    if (wr_ack) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ok_q    <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ok_q    <= pair_end && !toggled;
      fail_q  <= (state_q == ST_CMD_WR) && wr_ack;
    end
  end

  assign rd_req    = in_read;
  assign wr_req    = (state_q == ST_CMD_WR);
  assign wr_data   = DATA_W'(RESET_CMD);
  assign busy      = (state_q != ST_IDLE);
  assign done_ok   = ok_q;
  assign done_fail = fail_q;
endmodule

// File: rtl/tp_checker.sv
module tp_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic abort,
  input logic busy,
  input logic rd_req,
  input logic wr_req,
  input logic wr_ack,
  input logic done_ok,
  input logic done_fail,
  input logic pair_end,
  input logic toggled,
  input logic flag_set,
  input logic in_recheck
);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && rd_req);
  // R3
  steady_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_end && !toggled |=> done_ok && !wr_req);
  // R5
  recheck_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_end && toggled && flag_set && !in_recheck |=> rd_req && in_recheck);
  // R6
  recheck_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_end && toggled && in_recheck |=> wr_req);
  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req);
  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort && rd_req |=> !busy && !done_ok && !done_fail);
  // R10
  ok_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> !done_ok);
  // R10
  fail_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_fail |=> !done_fail);
  // R10
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok && done_fail));
  // R10
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok || done_fail) |-> !busy && $past(busy));
  // R2
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));
endmodule

bind toggle_poll_ctrl tp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .busy(busy),
  .rd_req(rd_req), .wr_req(wr_req), .wr_ack(wr_ack), .done_ok(done_ok),
  .done_fail(done_fail), .pair_end(pair_end), .toggled(toggled),
  .flag_set(flag_set), .in_recheck(in_recheck)
);

// File: tb/tb_toggle_poll_ctrl.sv
module tb_toggle_poll_ctrl;
  localparam int LIMIT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, abort = 1'b0, bit_sel = 1'b0;
  logic rd_ack = 1'b0, wr_ack = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic rd_req, wr_req, busy, done_ok, done_fail;
  logic [7:0] wr_data;

  always #10 clk = ~clk;

  toggle_poll_ctrl #(.MAX_PAIRS(LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .bit_sel(bit_sel),
    .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data), .wr_req(wr_req),
    .wr_data(wr_data), .wr_ack(wr_ack), .busy(busy), .done_ok(done_ok),
    .done_fail(done_fail)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // stimulus sources
  logic [7:0] stat_q[$];
  int  ack_gap = 0, gap_cnt = 0, wgap = 0;
  bit  req_start = 0, req_abort = 0, want_sel = 0;

  // observations
  int n_reads = 0, n_writes = 0, n_ok = 0, n_fail = 0;

  // reference model: phase 0 idle, 1 normal pair, 2 recheck pair, 3 command write
  int m_phase = 0, m_nrd = 0, m_pairs = 0;
  logic [7:0] m_first = 8'h00;
  bit m_sel = 0, m_ok = 0, m_fail = 0;

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    logic [7:0] b;
    int pos;
    bit tog;
    @(negedge clk);
    // compare every output with the model
    check(busy == (m_phase != 0), "R10", "busy", busy, m_phase != 0);
    check(rd_req == (m_phase == 1 || m_phase == 2), "R2", "rd_req", rd_req,
          m_phase == 1 || m_phase == 2);
    check(wr_req == (m_phase == 3), "R6", "wr_req", wr_req, m_phase == 3);
    check(done_ok == m_ok, "R10", "done_ok", done_ok, m_ok);
    check(done_fail == m_fail, "R10", "done_fail", done_fail, m_fail);
    if (wr_req) check(wr_data == 8'hF0, "R6", "wr_data", wr_data, 8'hF0);
    if (done_ok) n_ok++;
    if (done_fail) n_fail++;
    // drive inputs for the coming edge
    start = req_start; req_start = 0;
    abort = req_abort; req_abort = 0;
    bit_sel = want_sel;
    rd_ack = 1'b0;
    if (rd_req && gap_cnt >= ack_gap && stat_q.size() > 0) begin
      rd_ack = 1'b1;
      rd_data = stat_q.pop_front();
      gap_cnt = 0;
      n_reads++;
    end else if (rd_req) gap_cnt++;
    wr_ack = 1'b0;
    if (wr_req && wgap >= 2) begin
      wr_ack = 1'b1; wgap = 0; n_writes++;
    end else if (wr_req) wgap++;
    // advance model to the state after the next edge
    m_ok = 0; m_fail = 0;
    if (!rst_n) begin
      m_phase = 0;
    end else if (m_phase == 0) begin
      if (start) begin m_phase = 1; m_nrd = 0; m_pairs = 0; m_sel = bit_sel; end
    end else if (m_phase == 3) begin
      if (wr_ack) begin m_fail = 1; m_phase = 0; end
    end else if (abort) begin
      m_phase = 0;
    end else if (rd_ack) begin
      b = rd_data;
      if (m_nrd == 0) begin m_first = b; m_nrd = 1; end
      else begin
        pos = m_sel ? 2 : 6;
        tog = (m_first[pos] != b[pos]);
        m_nrd = 0;
        if (!tog) begin m_ok = 1; m_phase = 0; end
        else if (m_phase == 2) m_phase = 3;
        else if (b[5]) m_phase = 2;
        else if (m_pairs == LIMIT - 1) m_phase = 3;
        else m_pairs++;
      end
    end
  endtask

  task automatic run(input bit sel, input int gap);
    int k;
    int ok0, fail0;
    ok0 = n_ok; fail0 = n_fail;
    n_reads = 0; n_writes = 0;
    want_sel = sel; ack_gap = gap;
    req_start = 1;
    k = 0;
    while (n_ok == ok0 && n_fail == fail0 && k < 300) begin tick(); k++; end
    tick();
    stat_q.delete();
  endtask

  initial begin
    #400000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ok0;
    repeat (3) tick();
    // R1: reset state
    check(!busy && !rd_req && !wr_req && !done_ok && !done_fail, "R1", "outputs in reset",
          busy | rd_req | wr_req | done_ok | done_fail, 0);
    rst_n = 1'b1;
    tick();
    check(!busy && !rd_req && !wr_req, "R1", "outputs after reset", busy | rd_req | wr_req, 0);

    // R3: steady toggle bit, one pair, success
    stat_q = '{8'h44, 8'h44};
    run(0, 0);
    check(n_ok == 1 && n_fail == 0, "R3", "ok count", n_ok, 1);
    check(n_reads == 2 && n_writes == 0, "R3", "reads", n_reads, 2);

    // R4 and R2: toggling with flag low, then settles; extra start while busy ignored
    stat_q = '{8'h00, 8'h40, 8'h40, 8'h00, 8'h00, 8'h00};
    fork
      run(0, 1);
      begin repeat (4) @(posedge clk); req_start = 1; end
    join
    check(n_reads == 6 && n_writes == 0, "R4", "reads over three pairs", n_reads, 6);
    check(n_ok == 2, "R2", "ok count after ignored start", n_ok, 2);

    // R5: flag high, recheck steady -> ok
    stat_q = '{8'h20, 8'h60, 8'h60, 8'h60};
    run(0, 0);
    check(n_reads == 4 && n_writes == 0 && n_ok == 3, "R5", "recheck success reads", n_reads, 4);

    // R6: flag high, recheck still toggling -> reset write and fail
    stat_q = '{8'h20, 8'h60, 8'h20, 8'h60};
    run(0, 0);
    check(n_fail == 1 && n_writes == 1, "R6", "fail with F0 write", n_writes, 1);
    check(n_reads == 4, "R6", "reads before fail", n_reads, 4);

    // R7: bit_sel=1 ignores bit 6, follows bit 2
    stat_q = '{8'h00, 8'h40};
    run(1, 0);
    check(n_ok == 4 && n_reads == 2, "R7", "bit 6 ignored with sel=1", n_reads, 2);
    stat_q = '{8'h04, 8'h00, 8'h40, 8'h44, 8'h04, 8'h04};
    run(1, 0);
    check(n_ok == 5 && n_reads == 6, "R7", "bit 2 followed", n_reads, 6);

    // R8: abort mid pair, then restart from a fresh first read
    stat_q = '{8'h40};
    want_sel = 0; ack_gap = 0; n_reads = 0;
    req_start = 1;
    repeat (3) tick();
    req_abort = 1;
    ok0 = n_ok;
    repeat (3) tick();
    check(!busy && n_ok == ok0 && n_fail == 1, "R8", "idle without pulse after abort", busy, 0);
    stat_q = '{8'h00, 8'h00};
    run(0, 0);
    check(n_ok == ok0 + 1 && n_reads == 2, "R8", "restart uses new first read", n_reads, 2);

    // R9: toggling forever with flag low -> forced fail after LIMIT pairs
    for (int i = 0; i < LIMIT; i++) begin stat_q.push_back(8'h00); stat_q.push_back(8'h40); end
    run(0, 0);
    check(n_fail == 2 && n_writes == 1, "R9", "forced fail", n_fail, 2);
    check(n_reads == 2 * LIMIT, "R9", "pairs before forced fail", n_reads, 2 * LIMIT);

    repeat (3) tick();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule